// File: doc/BRIEF.md
# Dual-path SPI serial clock divider

This block turns a fast source clock into the bit clock of an SPI shift engine. It offers two divider paths. The coarse path divides by a power of two: a 3-bit code N gives a total divisor of 2^(N+2). The fine path divides linearly: an 8-bit code N gives a total divisor of 2×(N+1). A select input picks the path. The block produces a one-cycle `tick_o` at every half period, which is when the shift engine moves a serial clock edge, and a reference serial clock level `sclk_o` that toggles on each tick.

The shift engine raises `run_i` for the length of a transfer. The block latches the divider settings while it is idle and holds them for the whole active period. Changes made during a transfer therefore take effect only after `run_i` has been low for at least one cycle, and no shortened clock phase can appear. An optional lead-in delay, counted in source cycles, can separate the start of a transfer from the first clock phase.

Top module: `sclk_div`

## Requirements
- R1: After reset, `tick_o` and `sclk_o` are both 0.
- R2: When `lin_sel_i`=0, a half period lasts 2^(N+1) source cycles, where N = `pow2_code_i`. Codes 0, 1, 2 and 3 give full periods of 4, 8, 16 and 32 cycles, and code 7 gives 512.
- R3: When `lin_sel_i`=1, a half period lasts N+1 source cycles, where N = `lin_code_i`. Code 0 produces a tick on every cycle.
- R4: `lin_sel_i`=1 selects the linear path and `lin_sel_i`=0 selects the power-of-two path. The code of the unselected path has no effect on the outputs.
- R5: The block samples `run_i`=1 at an idle clock edge. With `lead_en_i`=1 and `lead_dly_i`=D, the first tick then comes D plus one half period after that edge.
- R6: With `lead_en_i`=0, `lead_dly_i` has no effect, and the first tick comes one half period after the start edge.
- R7: Divider codes, the path select and the lead settings are captured at the start edge. Changes to them while `run_i` stays high do not alter the tick spacing until the next idle period.
- R8: A clock edge that samples `run_i`=0 returns the block to idle and sets `sclk_o` to 0. A following start restarts the count from zero, so every phase has full length.
- R9: `sclk_o` toggles at the clock edge that follows a cycle with `tick_o`=1 (while `run_i` is still high), and at no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Transfer active request from the shift engine |
| pow2_code_i | input | 3 | Power-of-two divider code N |
| lin_code_i | input | 8 | Linear divider code N |
| lin_sel_i | input | 1 | 1: linear path, 0: power-of-two path |
| lead_dly_i | input | 16 | Lead-in delay in source cycles |
| lead_en_i | input | 1 | Enables the lead-in delay |
| tick_o | output | 1 | Half-period pulse, one cycle wide |
| sclk_o | output | 1 | Serial clock level, toggles on each tick |

## Verification
The assertions check, on every cycle, the behaviours that hold locally. `sclk_o` falls to 0 once the block goes idle. `sclk_o` changes only at the edge after a tick. No tick is issued during the lead-in. The latched divisor stays constant while a transfer runs, and the phase counter stays below that divisor. Whether the spacing of the ticks matches each code, the path select and the lead-in delay can only be shown by the bench's scenarios. The same holds for whether a setting changed during a transfer is ignored and then picked up after idle. In those scenarios, a reference model counts the cycles since the start and predicts every tick and level.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2
  } div_st_e;
endpackage

// File: rtl/sclk_half_calc.sv
module sclk_half_calc #(
  parameter int POW_W  = 3,
  parameter int LIN_W  = 8,
  parameter int HALF_W = 9
) (
  input  logic [POW_W-1:0]  pow2_code_i,
  input  logic [LIN_W-1:0]  lin_code_i,
  input  logic              lin_sel_i,
  output logic [HALF_W-1:0] half_o
);
  logic [HALF_W-1:0] half_pow;
  logic [HALF_W-1:0] half_lin;

  // half period in source cycles: 2^(N+1) or N+1
  assign half_pow = HALF_W'(2) << pow2_code_i;
  assign half_lin = HALF_W'(lin_code_i) + HALF_W'(1);
  assign half_o   = lin_sel_i ? half_lin : half_pow;
endmodule

// File: rtl/sclk_lead_ctl.sv
module sclk_lead_ctl
  import sclk_div_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DLY_W-1:0] lead_dly_i,
  input  logic             lead_en_i,
  output div_st_e          st_o
);
  div_st_e          st_q;
  logic [DLY_W-1:0] lcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      lcnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (run_i) begin
          if (lead_en_i && (lead_dly_i != '0)) begin
            st_q   <= ST_LEAD;
            lcnt_q <= lead_dly_i;
          end else begin
            st_q <= ST_RUN;
          end
        end
        ST_LEAD: begin
          lcnt_q <= lcnt_q - DLY_W'(1);
          if (!run_i)                      st_q <= ST_IDLE;
          else if (lcnt_q == DLY_W'(1))    st_q <= ST_RUN;
        end
        ST_RUN: if (!run_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/sclk_phase_cnt.sv
module sclk_phase_cnt
  import sclk_div_pkg::*;
#(
  parameter int HALF_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  div_st_e           st_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [HALF_W-1:0] half_o,
  output logic [HALF_W-1:0] cnt_o,
  output logic              tick_o,
  output logic              sclk_o
);
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt_q;
  logic              sclk_q;
  logic              tick;

  assign tick = (st_i == ST_RUN) && (cnt_q == half_q - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= HALF_W'(2);
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      // divisor only follows the settings while idle
      if (st_i == ST_IDLE) half_q <= half_i;
      if (st_i != ST_RUN || tick) cnt_q <= '0;
      else                        cnt_q <= cnt_q + HALF_W'(1);
      if (!run_i)     sclk_q <= 1'b0;
      else if (tick)  sclk_q <= ~sclk_q;
    end
  end

  assign half_o = half_q;
  assign cnt_o  = cnt_q;
  assign tick_o = tick;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/sclk_div.sv
module sclk_div
  import sclk_div_pkg::*;
#(
  parameter int POW_W = 3,
  parameter int LIN_W = 8,
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [POW_W-1:0] pow2_code_i,
  input  logic [LIN_W-1:0] lin_code_i,
  input  logic             lin_sel_i,
  input  logic [DLY_W-1:0] lead_dly_i,
  input  logic             lead_en_i,
  output logic             tick_o,
  output logic             sclk_o
);
  localparam int POW_HW = (2 ** POW_W) + 1;
  localparam int LIN_HW = LIN_W + 1;
  localparam int HALF_W = (POW_HW > LIN_HW) ? POW_HW : LIN_HW;

  div_st_e           st;
  logic [HALF_W-1:0] half_nxt;
  logic [HALF_W-1:0] half_lat;
  logic [HALF_W-1:0] cnt;

  sclk_half_calc #(.POW_W(POW_W), .LIN_W(LIN_W), .HALF_W(HALF_W)) u_calc (
    .pow2_code_i(pow2_code_i),
    .lin_code_i (lin_code_i),
    .lin_sel_i  (lin_sel_i),
    .half_o     (half_nxt)
  );

  sclk_lead_ctl #(.DLY_W(DLY_W)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .lead_dly_i(lead_dly_i),
    .lead_en_i (lead_en_i),
    .st_o      (st)
  );

  sclk_phase_cnt #(.HALF_W(HALF_W)) u_ph (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_i),
    .st_i  (st),
    .half_i(half_nxt),
    .half_o(half_lat),
    .cnt_o (cnt),
    .tick_o(tick_o),
    .sclk_o(sclk_o)
  );
endmodule

// File: rtl/sclk_div_chk.sv
module sclk_div_chk
  import sclk_div_pkg::*;
#(
  parameter int HALF_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              tick_o,
  input logic              sclk_o,
  input div_st_e           st,
  input logic [HALF_W-1:0] half_lat,
  input logic [HALF_W-1:0] cnt
);
  assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sclk_o);

  assert_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_o) |=> (sclk_o != $past(sclk_o)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> $stable(sclk_o));

  assert_no_tick_lead_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_RUN) |-> !tick_o);

  assert_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_IDLE && run_i) |=> $stable(half_lat));

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < half_lat);
endmodule

bind sclk_div sclk_div_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .tick_o  (tick_o),
  .sclk_o  (sclk_o),
  .st      (st),
  .half_lat(half_lat),
  .cnt     (cnt)
);

// File: tb/tb_sclk_div.sv
module tb_sclk_div;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [2:0]  pow2_code_i = '0;
  logic [7:0]  lin_code_i = '0;
  logic        lin_sel_i = 1'b0;
  logic [15:0] lead_dly_i = '0;
  logic        lead_en_i = 1'b0;
  logic        tick_o, sclk_o;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model state
  bit m_active = 1'b0;
  int m_age = 0;
  int m_half = 1;
  int m_lead = 0;

  sclk_div dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .pow2_code_i(pow2_code_i), .lin_code_i(lin_code_i), .lin_sel_i(lin_sel_i),
    .lead_dly_i(lead_dly_i), .lead_en_i(lead_en_i),
    .tick_o(tick_o), .sclk_o(sclk_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_active = 1'b0;
      m_age = 0;
    end else if (!m_active) begin
      if (run_i) begin
        m_active = 1'b1;
        m_age = 1;
        m_half = lin_sel_i ? (int'(lin_code_i) + 1) : (2 ** (int'(pow2_code_i) + 1));
        m_lead = lead_en_i ? int'(lead_dly_i) : 0;
      end
    end else if (!run_i) begin
      m_active = 1'b0;
      m_age = 0;
    end else begin
      m_age++;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit et, es;
      et = m_active && (m_age > m_lead) && (((m_age - m_lead) % m_half) == 0);
      es = m_active && (m_age > m_lead) && ((((m_age - m_lead - 1) / m_half) % 2) == 1);
      checks++;
      if (tick_o !== et || sclk_o !== es) begin
        errors++;
        $display("FAIL %s: tick=%b sclk=%b expected tick=%b sclk=%b (age %0d)",
                 cur_req, tick_o, sclk_o, et, es, m_age);
      end
    end
  end

  task automatic burst(input string req, input bit sel, input int p2, input int ln,
                       input bit den, input int dly, input int len);
    @(negedge clk_i);
    cur_req = req;
    lin_sel_i = sel; pow2_code_i = 3'(p2); lin_code_i = 8'(ln);
    lead_en_i = den; lead_dly_i = 16'(dly);
    run_i = 1'b1;
    repeat (len) @(negedge clk_i);
    run_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (tick_o !== 1'b0 || sclk_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: tick=%b sclk=%b expected 0 0", tick_o, sclk_o);
    end
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    // R2: power-of-two codes 0..3 and 7
    for (int c = 0; c < 4; c++) burst("R2", 1'b0, c, 37, 1'b0, 0, 90);
    burst("R2", 1'b0, 7, 0, 1'b0, 0, 1100);
    // R3: linear codes, including code 0
    burst("R3", 1'b1, 5, 0, 1'b0, 0, 20);
    burst("R3", 1'b1, 5, 1, 1'b0, 0, 30);
    burst("R3", 1'b1, 5, 6, 1'b0, 0, 60);
    burst("R3", 1'b1, 0, 255, 1'b0, 0, 1030);
    // R4: same codes, select flipped
    burst("R4", 1'b1, 1, 2, 1'b0, 0, 40);
    burst("R4", 1'b0, 1, 2, 1'b0, 0, 40);
    // R5: lead-in delay enabled
    burst("R5", 1'b0, 0, 0, 1'b1, 5, 40);
    burst("R5", 1'b1, 0, 3, 1'b1, 1, 40);
    burst("R5", 1'b1, 0, 3, 1'b1, 0, 40);
    // R6: delay value present but disabled
    burst("R6", 1'b1, 0, 3, 1'b0, 9, 40);
    // R7: settings change mid-transfer, then take effect after idle
    @(negedge clk_i);
    cur_req = "R7";
    lin_sel_i = 1'b0; pow2_code_i = 3'd1; lead_en_i = 1'b0;
    run_i = 1'b1;
    repeat (13) @(negedge clk_i);
    lin_sel_i = 1'b1; lin_code_i = 8'd0; pow2_code_i = 3'd3; lead_en_i = 1'b1; lead_dly_i = 16'd4;
    repeat (40) @(negedge clk_i);
    run_i = 1'b0;
    @(negedge clk_i);
    run_i = 1'b1;
    repeat (30) @(negedge clk_i);
    run_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R8: abort mid-phase, restart immediately
    @(negedge clk_i);
    cur_req = "R8";
    lin_sel_i = 1'b1; lin_code_i = 8'd4; lead_en_i = 1'b0;
    run_i = 1'b1;
    repeat (13) @(negedge clk_i);
    run_i = 1'b0;
    @(negedge clk_i);
    run_i = 1'b1;
    repeat (25) @(negedge clk_i);
    run_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R9: odd linear divisor, toggles on the edges after ticks
    burst("R9", 1'b1, 0, 2, 1'b0, 0, 50);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule